// File: doc/BRIEF.md
# Host Interrupt Gathering Controller

This block collects event pulses from five peripheral sources into sticky pending latches and raises a single level-type interrupt toward a host processor. The sources are an external pin event, a sample-rate timer, a tempo timer, an asynchronous serial port and a synchronous serial port. A source can latch only while its own enable bit is set and a chip-wide gate input is high. Once latched, an event stays pending until the host clears it.

The host sees one 16-bit register at one address, and reads and writes of it mean different things. A write carries the enable mask in its low byte lane and write-one-to-clear bits for the pending latches in its high byte lane. Each lane is controlled by its own byte strobe. A read returns only the pending latches. The enable mask cannot be read back. While any latch is pending, the interrupt output presents a fixed priority level. The host reads the register to find the cause and writes ones in the high lane to acknowledge.

The register bus has no wait states and no handshake. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the pending latches. Nothing in this block uses valid/ready flow control, because no data stream passes through it.

Top module: `host_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the enable mask and every pending latch are 0, `irq_level` is 0, and events arriving before the mask is written latch nothing.
- R2: A write with `bus_be[0]`=1 loads `bus_wdata[4:0]` into the enable mask from the next cycle on. A full-word write (`bus_be`=2'b11) does both lane actions in the same cycle.
- R3: A write with `bus_be[1]`=1 clears each pending latch whose bit in `bus_wdata[12:8]` is 1. Latches whose bits are 0 keep their state.
- R4: While `bus_sel`=1 and `bus_we`=0, `bus_rdata[4:0]` shows the pending latches and never the enable mask. While `bus_sel`=0, `bus_rdata` is 0.
- R5: Source i sets its pending latch on a cycle where `evt_i[i]`=1 only if mask bit i is 1 and `gate_i`=1. The bit positions are: external = 0, sample timer = 1, tempo timer = 2, asynchronous serial = 3, synchronous serial = 4.
- R6: A pending latch holds its value until a high-lane clear hits it. Rewriting the mask, including to 0, leaves existing pending bits untouched.
- R7: If a qualified event and a clear of the same bit fall on the same cycle, the bit ends up set.
- R8: `irq_level` is 3'd2 whenever any pending latch is set, and 3'd0 otherwise.
- R9: Write data bits 7:5 and 15:13 have no effect, and `bus_rdata[15:5]` always reads 0.
- R10: With `bus_we`=0 or `bus_sel`=0, the mask and the pending latches are not changed by `bus_wdata` or `bus_be`.
- R11: An event on the same cycle as a mask write is qualified by the old mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the mask and the latches |
| evt_i | input | 5 | Per-source event pulses (bit 0 external ... bit 4 synchronous serial) |
| gate_i | input | 1 | Chip-wide qualifier; events latch only while high |
| bus_sel | input | 1 | Register select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte strobes: bit 0 low lane (mask), bit 1 high lane (clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Pending latches in bits 4:0, zeros above |
| irq_level | output | 3 | Host interrupt priority level: 2 when pending, else 0 |

## Verification
The assertions assume that every input is a known 0 or 1 on each rising edge. They also assume that an event is judged by its level on that edge, whether it is a one-cycle pulse or held high. The bench keeps within these assumptions by changing every input only on falling edges. It drives each stimulus vector for exactly one cycle and then returns the bus to a plain read with all events low. As a result, each latch change can be traced to a single edge, and the readback that follows shows it.

// File: rtl/hic_pkg.sv
package hic_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned SRC_N  = 5;
  localparam int unsigned LVL_W  = 3;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_wr_t;
endpackage

// File: rtl/hic_bus_decode.sv
module hic_bus_decode
  import hic_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned DW    = BUS_W,
  parameter int unsigned LW    = LANE_W
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output lane_wr_t         lane_wr,
  output logic [N_SRC-1:0] mask_d,
  output logic [N_SRC-1:0] clr_vec
);
  localparam int unsigned HI_BASE = LW;

  logic wr_cycle;
  logic unused_rsvd_bits;

  assign wr_cycle   = bus_sel && bus_we;
  assign lane_wr.lo = wr_cycle && bus_be[0];
  assign lane_wr.hi = wr_cycle && bus_be[1];

  assign mask_d  = bus_wdata[N_SRC-1:0];
  assign clr_vec = lane_wr.hi ? bus_wdata[HI_BASE +: N_SRC] : '0;

  // reserved data bits are deliberately dropped
  assign unused_rsvd_bits = ^{bus_wdata[LW-1:N_SRC], bus_wdata[DW-1:HI_BASE+N_SRC]};
endmodule

// File: rtl/hic_mask_reg.sv
module hic_mask_reg #(
  parameter int unsigned N_SRC = hic_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_SRC-1:0] d,
  output logic [N_SRC-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/hic_pending_bank.sv
module hic_pending_bank #(
  parameter int unsigned N_SRC = hic_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             gate_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] set_o,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    assign set_o[g] = evt_i[g] && en_i[g] && gate_i;

    // set has priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[g] <= 1'b0;
      else if (set_o[g]) pend_q[g] <= 1'b1;
      else if (clr_i[g]) pend_q[g] <= 1'b0;
    end

    // R5
    pend_rise_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(evt_i[g] && en_i[g] && gate_i));

    // R7
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[g] && en_i[g] && gate_i && clr_i[g]) |=> pend_q[g]);

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !(evt_i[g] && en_i[g] && gate_i)) |=> !pend_q[g]);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hic_pkg::*;
#(
  parameter int unsigned N_SRC     = SRC_N,
  parameter int unsigned DW        = BUS_W,
  parameter int unsigned LW        = LANE_W,
  parameter int unsigned LW_LVL    = LVL_W,
  parameter int unsigned IRQ_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              gate_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [LW_LVL-1:0] irq_level
);
  localparam logic [LW_LVL-1:0] LVL_ON = LW_LVL'(IRQ_LEVEL);

  lane_wr_t         lane_wr;
  logic [N_SRC-1:0] mask_d;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] pend_q;

  hic_bus_decode #(.N_SRC(N_SRC), .DW(DW), .LW(LW)) u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .lane_wr   (lane_wr),
    .mask_d    (mask_d),
    .clr_vec   (clr_vec)
  );

  hic_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lane_wr.lo),
    .d     (mask_d),
    .q     (mask_q)
  );

  hic_pending_bank #(.N_SRC(N_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .en_i   (mask_q),
    .gate_i (gate_i),
    .clr_i  (clr_vec),
    .set_o  (set_vec),
    .pend_q (pend_q)
  );

  assign bus_rdata = (bus_sel && !bus_we) ? {{(DW-N_SRC){1'b0}}, pend_q} : '0;
  assign irq_level = (|pend_q) ? LVL_ON : '0;

  // R8
  irq_level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) || (irq_level == LVL_ON));

  // R8
  irq_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (irq_level == LVL_ON));

  // R9
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:N_SRC] == '0);

  // R4
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/tb_host_irq_ctrl.sv
`timescale 1ns/1ps
module tb_host_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_i = '0;
  logic        gate_i = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  host_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .gate_i(gate_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_level(irq_level)
  );

  // {be[2], we, wdata[16], evt[5], gate, exp_pend[5], exp_irq[3]}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {2'b00, 1'b0, 16'h0000, 5'b11111, 1'b1, 5'b00000, 3'd0}, // R1 R5: mask still 0
    {2'b11, 1'b1, 16'h001F, 5'b00000, 1'b0, 5'b00000, 3'd0}, // R2: enable all
    {2'b00, 1'b0, 16'h0000, 5'b00001, 1'b0, 5'b00000, 3'd0}, // R5: gate low
    {2'b00, 1'b0, 16'h0000, 5'b00101, 1'b1, 5'b00101, 3'd2}, // R5 R8
    {2'b10, 1'b1, 16'h0400, 5'b00000, 1'b0, 5'b00001, 3'd2}, // R3: clear bit 2
    {2'b01, 1'b1, 16'h0012, 5'b00000, 1'b0, 5'b00001, 3'd2}, // R6: mask rewrite keeps pending
    {2'b00, 1'b0, 16'h0000, 5'b11111, 1'b1, 5'b10011, 3'd2}, // R5: only bits 1,4 enabled
    {2'b11, 1'b1, 16'hFF00, 5'b00010, 1'b1, 5'b00010, 3'd2}, // R7 R11: set wins, old mask
    {2'b00, 1'b0, 16'h0000, 5'b11111, 1'b1, 5'b00010, 3'd2}, // R2: mask now 0
    {2'b10, 1'b1, 16'h0200, 5'b00000, 1'b0, 5'b00000, 3'd0}, // R3 R8: all clear, irq off
    {2'b11, 1'b1, 16'hE0E8, 5'b00000, 1'b0, 5'b00000, 3'd0}, // R9: reserved bits dropped
    {2'b00, 1'b0, 16'h0000, 5'b11111, 1'b1, 5'b01000, 3'd2}, // R9: mask is bit 3 only
    {2'b10, 1'b1, 16'hE0FF, 5'b00000, 1'b0, 5'b01000, 3'd2}, // R9: high reserved no clear
    {2'b11, 1'b0, 16'h1F1F, 5'b10000, 1'b1, 5'b01000, 3'd2}, // R10: read does not write
    {2'b01, 1'b1, 16'h0010, 5'b00000, 1'b0, 5'b01000, 3'd2}, // R2: mask bit 4
    {2'b00, 1'b0, 16'h0000, 5'b10000, 1'b1, 5'b11000, 3'd2}  // R4 R5: read shows pending
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1/R5";
      1, 8, 14: return "R2";
      2, 3, 6: return "R5";
      4, 9: return "R3";
      5: return "R6";
      7: return "R7/R11";
      10, 11, 12: return "R9";
      13: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_read();
    bus_sel = 1'b1; bus_we = 1'b0; bus_be = 2'b00; bus_wdata = '0;
    evt_i = '0; gate_i = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_read();
    repeat (3) @(negedge clk);
    // R1: state during reset
    #1;
    check16("R1 rdata in reset", bus_rdata, 16'h0000);
    check16("R1 irq in reset", {13'd0, irq_level}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check16("R1 rdata after reset", bus_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_be    = VEC[i][32:31];
      bus_we    = VEC[i][30];
      bus_wdata = VEC[i][29:14];
      evt_i     = VEC[i][13:9];
      gate_i    = VEC[i][8];
      @(negedge clk);
      idle_read();
      #1;
      check16({vtag(i), " pending"}, bus_rdata, {11'd0, VEC[i][7:3]});
      check16({vtag(i), " irq_level"}, {13'd0, irq_level}, {13'd0, VEC[i][2:0]});
    end

    // R4: deselected bus reads zero even with pending set
    @(negedge clk);
    bus_sel = 1'b0;
    #1;
    check16("R4 deselected rdata", bus_rdata, 16'h0000);
    check16("R8 irq while pending", {13'd0, irq_level}, 16'h0002);

    // R10: write data with sel low is ignored
    bus_we = 1'b1; bus_be = 2'b11; bus_wdata = 16'hFF00;
    @(negedge clk);
    idle_read();
    #1;
    check16("R10 sel-low write", bus_rdata, 16'h0018);

    // R1: reset mid-run clears pending and mask
    rst_n = 1'b0;
    #1;
    check16("R1 mid-run reset rdata", bus_rdata, 16'h0000);
    check16("R1 mid-run reset irq", {13'd0, irq_level}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    evt_i = 5'b11111; gate_i = 1'b1;
    @(negedge clk);
    idle_read();
    #1;
    check16("R1 mask cleared by reset", bus_rdata, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule